// File: doc/BRIEF.md
# Microstep-Sequenced State Diagram Controller

This block is a control unit that carries out the output operations of a small state diagram as ordered series of single-cycle microstep pulses. Rather than one monolithic case-based machine, it is split into a skeletal state register, a 3-bit slot counter with a one-hot slot decoder, and an AND-OR term array. Each microstep term is the AND of one current-state line, one slot line and (where needed) one qualified input condition line. All terms that produce the same microstep are merged by OR onto a single output pulse line.

The controller drives the register gates and memory strobes of a surrounding datapath: bumping an I/O address counter, gating that counter or a table counter to the memory address register, saving the I/O counter, loading the table counter with a fixed constant, issuing a memory read, and signalling that a state change takes place. Four example states are implemented: idle (0), setup (1), compare (2) and advance (3). A transition runs its microsteps from slot 1 upward. The last microstep of every transition is the change pulse, which loads the next state and returns the slot counter to slot 1 on the same clock edge.

Top module: `mstep_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in state 0 with the slot counter at slot 1 (`cur_slot` = 0). While reset is high every microstep output is low, even in the middle of a transition.
- R2: At most one microstep output is high in any cycle, and a transition produces exactly one pulse per slot.
- R3: `cur_state` changes only on the clock edge that ends a cycle with `change_state` high. After that edge `cur_slot` reads 0.
- R4: When the current state and the inputs select no transition (state 0 without `start_req`), all outputs stay low and the slot counter holds at slot 1.
- R5: In state 0 with `start_req`, slot 1 carries `change_state` only, and the next state is 1.
- R6: In state 1, regardless of the inputs, the slots carry in order: `save_io_ctr`, `load_tbl_ctr`, `tbl_ctr_to_mar`, `mem_read`, `change_state`. The next state is 2. `tbl_load_val` equals 16'h4095 (binary 0100 0000 1001 0101) while `load_tbl_ctr` is high.
- R7: In state 2 with `hit`, the slots carry in order: `inc_io_ctr`, `io_ctr_to_mar`, `mem_read`, `change_state`. The next state is 3.
- R8: In state 2 with `miss` and without `hit`, the slots carry in order: `tbl_ctr_to_mar`, `mem_read`, `change_state`. The next state is 2.
- R9: In state 2, `hit` takes priority over `miss` when both are high.
- R10: In state 3 with `var_mark` and without `end_mark`, eight slots carry in order: `inc_io_ctr`, `io_ctr_to_mar`, `mem_read`, `save_io_ctr`, `load_tbl_ctr`, `tbl_ctr_to_mar`, `mem_read`, `change_state`. The next state is 2.
- R11: In state 3 with `end_mark`, slot 1 carries `change_state` only, and the next state is 0. `end_mark` takes priority over `var_mark`.
- R12: In state 2 without `hit` or `miss`, and in state 3 without `end_mark` or `var_mark`, the controller idles as in R4 but keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to leave the idle state |
| hit | input | 1 | Comparison found a match |
| miss | input | 1 | Comparison found no match |
| end_mark | input | 1 | End symbol seen |
| var_mark | input | 1 | Variable symbol seen |
| inc_io_ctr | output | 1 | Pulse: increment the I/O address counter |
| io_ctr_to_mar | output | 1 | Pulse: gate the I/O counter to the memory address register |
| save_io_ctr | output | 1 | Pulse: copy the I/O counter into its holding register |
| load_tbl_ctr | output | 1 | Pulse: load the table counter with `tbl_load_val` |
| tbl_ctr_to_mar | output | 1 | Pulse: gate the table counter to the memory address register |
| mem_read | output | 1 | Pulse: start a memory read cycle |
| change_state | output | 1 | Pulse: final microstep; the next state loads on this edge |
| tbl_load_val | output | 16 | Constant loaded into the table counter |
| cur_state | output | 2 | Current state number (0 to 3) |
| cur_slot | output | 3 | Current slot, 0 meaning slot 1 |

## Verification
The assertions assume that the condition inputs stay steady from the first slot of a transition until the cycle of its change pulse, because a term array gated by live inputs cannot keep the order if a condition drops out mid-run. The bench picks inputs at random from a fixed seed, biased so that every transition and every priority overlap occurs. It changes them only on the falling edge that follows a change pulse, or after a single idle cycle. Directed cases add a reset in the middle of a run, idling in each state, and the two priority collisions.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int STATE_W   = 2;
    localparam int NUM_STATES = 1 << STATE_W;
    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int NUM_STEPS = 7;
    localparam int NUM_CONDS = 6;
    localparam int NUM_TERMS = 22;
    localparam int TBL_W     = 16;
    localparam logic [TBL_W-1:0] TBL_INIT = 16'h4095;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_COMPARE = 2'd2,
        ST_ADVANCE = 2'd3
    } ctl_state_e;

    // qualified condition line indices
    localparam int C_ALWAYS = 0;
    localparam int C_START  = 1;
    localparam int C_HIT    = 2;
    localparam int C_MISS   = 3;
    localparam int C_END    = 4;
    localparam int C_VAR    = 5;

    // microstep output line indices
    localparam int MS_INC_IO  = 0;
    localparam int MS_IO_MAR  = 1;
    localparam int MS_SAVE_IO = 2;
    localparam int MS_LOAD_TB = 3;
    localparam int MS_TB_MAR  = 4;
    localparam int MS_READ    = 5;
    localparam int MS_CHANGE  = 6;

    typedef logic [NUM_CONDS-1:0] cond_vec_t;
    typedef logic [NUM_STEPS-1:0] step_vec_t;

    typedef struct packed {
        logic [STATE_W-1:0] st;
        logic [2:0]         cond;
        logic [SLOT_W-1:0]  slot;
        logic [2:0]         step;
    } term_t;

    function automatic term_t mk(input int st, input int cond, input int slot, input int step);
        term_t t;
        t.st   = STATE_W'(st);
        t.cond = 3'(cond);
        t.slot = SLOT_W'(slot);
        t.step = 3'(step);
        return t;
    endfunction

    // the AND-plane: one entry per microstep term
    function automatic term_t term_at(input int i);
        case (i)
            0:  return mk(0, C_START,  0, MS_CHANGE);
            1:  return mk(1, C_ALWAYS, 0, MS_SAVE_IO);
            2:  return mk(1, C_ALWAYS, 1, MS_LOAD_TB);
            3:  return mk(1, C_ALWAYS, 2, MS_TB_MAR);
            4:  return mk(1, C_ALWAYS, 3, MS_READ);
            5:  return mk(1, C_ALWAYS, 4, MS_CHANGE);
            6:  return mk(2, C_HIT,    0, MS_INC_IO);
            7:  return mk(2, C_HIT,    1, MS_IO_MAR);
            8:  return mk(2, C_HIT,    2, MS_READ);
            9:  return mk(2, C_HIT,    3, MS_CHANGE);
            10: return mk(2, C_MISS,   0, MS_TB_MAR);
            11: return mk(2, C_MISS,   1, MS_READ);
            12: return mk(2, C_MISS,   2, MS_CHANGE);
            13: return mk(3, C_VAR,    0, MS_INC_IO);
            14: return mk(3, C_VAR,    1, MS_IO_MAR);
            15: return mk(3, C_VAR,    2, MS_READ);
            16: return mk(3, C_VAR,    3, MS_SAVE_IO);
            17: return mk(3, C_VAR,    4, MS_LOAD_TB);
            18: return mk(3, C_VAR,    5, MS_TB_MAR);
            19: return mk(3, C_VAR,    6, MS_READ);
            20: return mk(3, C_VAR,    7, MS_CHANGE);
            default: return mk(3, C_END, 0, MS_CHANGE);
        endcase
    endfunction

    // OR-plane mask: which terms feed a given microstep line
    function automatic logic [NUM_TERMS-1:0] step_mask(input int step);
        logic [NUM_TERMS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_TERMS; i++) begin
            m[i] = (int'(term_at(i).step) == step);
        end
        return m;
    endfunction

    // skeleton: does the present state see a usable input?
    function automatic logic trans_selected(input ctl_state_e st, input cond_vec_t c);
        case (st)
            ST_IDLE:    return c[C_START];
            ST_SETUP:   return c[C_ALWAYS];
            ST_COMPARE: return c[C_HIT] | c[C_MISS];
            default:    return c[C_END] | c[C_VAR];
        endcase
    endfunction

    // skeleton: destination once the change microstep fires
    function automatic ctl_state_e next_state(input ctl_state_e st, input cond_vec_t c);
        case (st)
            ST_IDLE:    return c[C_START] ? ST_SETUP : ST_IDLE;
            ST_SETUP:   return ST_COMPARE;
            ST_COMPARE: return c[C_HIT] ? ST_ADVANCE : ST_COMPARE;
            default:    return c[C_END] ? ST_IDLE : (c[C_VAR] ? ST_COMPARE : ST_ADVANCE);
        endcase
    endfunction

endpackage

// File: rtl/mstep_cond_qual.sv
module mstep_cond_qual
    import mstep_pkg::*;
(
    input  logic      start_req,
    input  logic      hit,
    input  logic      miss,
    input  logic      end_mark,
    input  logic      var_mark,
    output cond_vec_t cond
);
    always_comb begin
        cond           = '0;
        cond[C_ALWAYS] = 1'b1;
        cond[C_START]  = start_req;
        cond[C_HIT]    = hit;
        cond[C_MISS]   = miss & ~hit;         // match wins
        cond[C_END]    = end_mark;
        cond[C_VAR]    = var_mark & ~end_mark; // end symbol wins
    end
endmodule

// File: rtl/mstep_skeleton.sv
module mstep_skeleton
    import mstep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chg,
    input  cond_vec_t             cond,
    output ctl_state_e            state,
    output logic [NUM_STATES-1:0] state_line,
    output logic                  active
);
    ctl_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (chg) begin
            state_q <= next_state(state_q, cond);
        end
    end

    assign state  = state_q;
    assign active = trans_selected(state_q, cond);

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_state_dec
        assign state_line[s] = (state_q == ctl_state_e'(s));
    end
endmodule

// File: rtl/mstep_slot_ctr.sv
module mstep_slot_ctr
    import mstep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 chg,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_SLOTS-1:0] slot_line
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || chg) begin
            cnt_q <= '0;
        end else if (active && cnt_q != SLOT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot = cnt_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_dec
        assign slot_line[k] = (cnt_q == SLOT_W'(k));
    end
endmodule

// File: rtl/mstep_and_or.sv
module mstep_and_or
    import mstep_pkg::*;
(
    input  logic [NUM_STATES-1:0] state_line,
    input  logic [NUM_SLOTS-1:0]  slot_line,
    input  cond_vec_t             cond,
    output step_vec_t             steps
);
    logic [NUM_TERMS-1:0] term_hit;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_and
        localparam term_t TERM = term_at(t);
        assign term_hit[t] = state_line[TERM.st] & slot_line[TERM.slot] & cond[TERM.cond];
    end

    for (genvar s = 0; s < NUM_STEPS; s++) begin : g_or
        localparam logic [NUM_TERMS-1:0] MASK = step_mask(s);
        assign steps[s] = |(term_hit & MASK);
    end
endmodule

// File: rtl/mstep_seq_ctrl.sv
module mstep_seq_ctrl
    import mstep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               hit,
    input  logic               miss,
    input  logic               end_mark,
    input  logic               var_mark,
    output logic               inc_io_ctr,
    output logic               io_ctr_to_mar,
    output logic               save_io_ctr,
    output logic               load_tbl_ctr,
    output logic               tbl_ctr_to_mar,
    output logic               mem_read,
    output logic               change_state,
    output logic [TBL_W-1:0]   tbl_load_val,
    output logic [STATE_W-1:0] cur_state,
    output logic [SLOT_W-1:0]  cur_slot
);
    cond_vec_t             cond;
    ctl_state_e            state;
    logic [NUM_STATES-1:0] state_line;
    logic [NUM_SLOTS-1:0]  slot_line;
    logic                  active;
    step_vec_t             steps;
    step_vec_t             steps_g;

    mstep_cond_qual u_qual (
        .start_req (start_req),
        .hit       (hit),
        .miss      (miss),
        .end_mark  (end_mark),
        .var_mark  (var_mark),
        .cond      (cond)
    );

    mstep_skeleton u_skel (
        .clk        (clk),
        .rst        (rst),
        .chg        (steps_g[MS_CHANGE]),
        .cond       (cond),
        .state      (state),
        .state_line (state_line),
        .active     (active)
    );

    mstep_slot_ctr u_slot (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .chg       (steps_g[MS_CHANGE]),
        .slot      (cur_slot),
        .slot_line (slot_line)
    );

    mstep_and_or u_array (
        .state_line (state_line),
        .slot_line  (slot_line),
        .cond       (cond),
        .steps      (steps)
    );

    assign steps_g        = rst ? '0 : steps;
    assign inc_io_ctr     = steps_g[MS_INC_IO];
    assign io_ctr_to_mar  = steps_g[MS_IO_MAR];
    assign save_io_ctr    = steps_g[MS_SAVE_IO];
    assign load_tbl_ctr   = steps_g[MS_LOAD_TB];
    assign tbl_ctr_to_mar = steps_g[MS_TB_MAR];
    assign mem_read       = steps_g[MS_READ];
    assign change_state   = steps_g[MS_CHANGE];
    assign tbl_load_val   = TBL_INIT;
    assign cur_state      = state;
endmodule

// File: rtl/mstep_seq_ctrl_chk.sv
module mstep_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_req,
    input logic       hit,
    input logic       end_mark,
    input logic       inc_io_ctr,
    input logic       io_ctr_to_mar,
    input logic       save_io_ctr,
    input logic       load_tbl_ctr,
    input logic       tbl_ctr_to_mar,
    input logic       mem_read,
    input logic       change_state,
    input logic [1:0] cur_state,
    input logic [2:0] cur_slot
);
    logic [6:0] pulses;
    assign pulses = {change_state, mem_read, tbl_ctr_to_mar, load_tbl_ctr,
                     save_io_ctr, io_ctr_to_mar, inc_io_ctr};

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |-> pulses == 7'd0);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulses));

    assert_state_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !change_state |=> $stable(cur_state));

    assert_slot_restart_R3: assert property (@(posedge clk) disable iff (rst)
        change_state |=> cur_slot == 3'd0);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 2'd0 && !start_req) |-> (pulses == 7'd0 && cur_slot == 3'd0));

    assert_start_change_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 2'd0 && start_req) |-> change_state);

    assert_setup_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 2'd1 && change_state) |=> cur_state == 2'd2);

    assert_hit_first_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 2'd2 && hit && cur_slot == 3'd0) |-> inc_io_ctr);

    assert_end_exit_R11: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 2'd3 && end_mark && change_state) |=> cur_state == 2'd0);
endmodule

bind mstep_seq_ctrl mstep_seq_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_req      (start_req),
    .hit            (hit),
    .end_mark       (end_mark),
    .inc_io_ctr     (inc_io_ctr),
    .io_ctr_to_mar  (io_ctr_to_mar),
    .save_io_ctr    (save_io_ctr),
    .load_tbl_ctr   (load_tbl_ctr),
    .tbl_ctr_to_mar (tbl_ctr_to_mar),
    .mem_read       (mem_read),
    .change_state   (change_state),
    .cur_state      (cur_state),
    .cur_slot       (cur_slot)
);

// File: tb/mstep_seq_ctrl_tb.sv
module mstep_seq_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int WATCHDOG = 100000;

    // expected pulse codes: bit0 inc, 1 io->mar, 2 save, 3 load, 4 tbl->mar, 5 read, 6 change
    localparam logic [6:0] P_INC = 7'h01, P_IOM = 7'h02, P_SAV = 7'h04, P_LD = 7'h08,
                           P_TBM = 7'h10, P_RD = 7'h20, P_CHG = 7'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 0, hit = 0, miss = 0, end_mark = 0, var_mark = 0;
    logic inc_io_ctr, io_ctr_to_mar, save_io_ctr, load_tbl_ctr, tbl_ctr_to_mar, mem_read, change_state;
    logic [15:0] tbl_load_val;
    logic [1:0]  cur_state;
    logic [2:0]  cur_slot;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int m_state = 0;

    always #(CLK_P/2) clk = ~clk;

    mstep_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .hit(hit), .miss(miss),
        .end_mark(end_mark), .var_mark(var_mark), .inc_io_ctr(inc_io_ctr),
        .io_ctr_to_mar(io_ctr_to_mar), .save_io_ctr(save_io_ctr),
        .load_tbl_ctr(load_tbl_ctr), .tbl_ctr_to_mar(tbl_ctr_to_mar),
        .mem_read(mem_read), .change_state(change_state),
        .tbl_load_val(tbl_load_val), .cur_state(cur_state), .cur_slot(cur_slot)
    );

    function automatic logic [6:0] pulses();
        return {change_state, mem_read, tbl_ctr_to_mar, load_tbl_ctr,
                save_io_ctr, io_ctr_to_mar, inc_io_ctr};
    endfunction

    // transition id: 0 none, 1 start, 2 setup, 3 hit, 4 miss, 5 var, 6 end
    function automatic int trans_id(input int st);
        case (st)
            0: return start_req ? 1 : 0;
            1: return 2;
            2: return hit ? 3 : (miss ? 4 : 0);
            default: return end_mark ? 6 : (var_mark ? 5 : 0);
        endcase
    endfunction

    function automatic int seq_len(input int id);
        case (id)
            1: return 1; 2: return 5; 3: return 4; 4: return 3; 5: return 8; 6: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [6:0] seq_code(input int id, input int k);
        logic [6:0] s1 [5] = '{P_SAV, P_LD, P_TBM, P_RD, P_CHG};
        logic [6:0] s3 [4] = '{P_INC, P_IOM, P_RD, P_CHG};
        logic [6:0] s4 [3] = '{P_TBM, P_RD, P_CHG};
        logic [6:0] s5 [8] = '{P_INC, P_IOM, P_RD, P_SAV, P_LD, P_TBM, P_RD, P_CHG};
        case (id)
            1, 6: return P_CHG;
            2: return s1[k];
            3: return s3[k];
            4: return s4[k];
            5: return s5[k];
            default: return 7'h00;
        endcase
    endfunction

    function automatic int next_of(input int id, input int st);
        case (id)
            1: return 1; 2: return 2; 3: return 3; 4: return 2; 5: return 2; 6: return 0;
            default: return st;
        endcase
    endfunction

    function automatic string tag_of(input int id, input int st);
        case (id)
            1: return "R5"; 2: return "R6"; 3: return "R7"; 4: return "R8";
            5: return "R10"; 6: return "R11";
            default: return (st == 0) ? "R4" : "R12";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge with inputs set; returns just after a falling edge.
    task automatic run_trans(input string force_tag);
        int id = trans_id(m_state);
        int n = seq_len(id);
        int nx = next_of(id, m_state);
        string tag = (force_tag == "") ? tag_of(id, m_state) : force_tag;
        if (n == 0) begin
            #(CLK_P/4);
            check(pulses() == 7'h00, tag, "idle pulses", pulses(), 0);
            check(cur_slot == 3'd0, tag, "idle slot", cur_slot, 0);
            @(negedge clk);
            check(cur_slot == 3'd0, tag, "idle slot held", cur_slot, 0);
        end else begin
            for (int k = 0; k < n; k++) begin
                #(CLK_P/4);
                check(pulses() == seq_code(id, k), tag, $sformatf("slot %0d pulse", k+1),
                      pulses(), seq_code(id, k));
                check(cur_slot == 3'(k), "R2", "slot count", cur_slot, k);
                if (k < n-1)
                    check(int'(cur_state) == m_state, "R3", "state before change", cur_state, m_state);
                if (load_tbl_ctr)
                    check(tbl_load_val == 16'h4095, "R6", "load constant", tbl_load_val, 16'h4095);
                @(negedge clk);
            end
            check(cur_slot == 3'd0, "R3", "slot after change", cur_slot, 0);
        end
        check(int'(cur_state) == nx, tag, "next state", cur_state, nx);
        m_state = nx;
    endtask

    task automatic set_in(input logic s, input logic h, input logic m, input logic e, input logic v);
        start_req = s; hit = h; miss = m; end_mark = e; var_mark = v;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        set_in(0, 1, 1, 1, 1);
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        check(pulses() == 7'h00, "R1", "pulses in reset", pulses(), 0);
        @(negedge clk);
        rst = 1'b0;
        check(cur_state == 2'd0, "R1", "reset state", cur_state, 0);
        check(cur_slot == 3'd0, "R1", "reset slot", cur_slot, 0);
        m_state = 0;

        // R4: idle with other inputs high but no start
        set_in(0, 1, 1, 1, 1);
        for (int i = 0; i < 3; i++) run_trans("R4");

        set_in(1, 0, 0, 0, 0); run_trans("R5");
        set_in(0, 1, 0, 1, 0); run_trans("R6");   // setup ignores inputs
        set_in(0, 0, 0, 0, 0); run_trans("R12");  // compare idles
        set_in(0, 0, 1, 0, 0); run_trans("R8");
        set_in(0, 1, 1, 0, 0); run_trans("R9");   // hit wins over miss
        set_in(0, 0, 0, 0, 0); run_trans("R12");  // advance idles
        set_in(0, 0, 0, 0, 1); run_trans("R10");
        set_in(0, 1, 0, 0, 0); run_trans("R7");
        set_in(0, 0, 0, 1, 1); run_trans("R11");  // end wins over var
        check(cur_state == 2'd0, "R11", "back to idle", cur_state, 0);

        // R1: reset in the middle of the setup run
        set_in(1, 0, 0, 0, 0); run_trans("R5");
        set_in(0, 0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        #(CLK_P/4);
        check(pulses() == 7'h00, "R1", "pulses during mid-run reset", pulses(), 0);
        @(negedge clk);
        rst = 1'b0;
        check(cur_state == 2'd0, "R1", "state after mid-run reset", cur_state, 0);
        check(cur_slot == 3'd0, "R1", "slot after mid-run reset", cur_slot, 0);
        m_state = 0;

        // constrained random transitions
        for (int i = 0; i < 400; i++) begin
            set_in(($urandom % 3) != 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                   ($urandom % 3) == 0, ($urandom % 2) == 0);
            run_trans("");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule